// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block is an always-on front end for a bank of up to 126 peripheral interrupt lines. It feeds a downstream interrupt controller that only accepts active-high levels and rising edges. Each line has its own enable bit and its own trigger type. Active-low levels are inverted, and falling edges are turned into rising edges. The result is forwarded on a matching output line, as a level or as a one-cycle pulse.

While the main domain is down (`domain_ready` low), edge events on enabled lines are held in a sticky pending bit per line, and a wake request is raised. An enabled level line that is active while the domain is down also raises the wake request. When `domain_ready` returns, each pending line sends exactly one replay pulse and its pending bit clears.

Software programs the enables and trigger types through a simple register port. Reads return data one cycle after the read strobe. Input lines pass through a two-flop synchronizer. After that, each forwarded output takes one more register stage.

Top module: `wake_irq_norm`

## Requirements
- R1: After reset, every output line and `wake_req` are low, every enable bit reads 0, and every pin's trigger register reads 0x4 (level, active high).
- R2: Enable bits sit in 32-bit words at byte address 0x10 + 4*(p/32), with pin p on bit p%32. Written values read back one cycle after the read strobe. Bits for pins at or above the pin count, and enable words past the last one, read zero.
- R3: Pin p's trigger register is at byte address 0x110 + 4*p. Bit 2 selects polarity (1 = high/rising, 0 = low/falling) and bit 1 selects edge mode (1 = edge, 0 = level). All other bits read zero.
- R4: Trigger type 3'b100 (level high): an enabled output follows its input, appearing at the third clock edge after the input changes.
- R5: Trigger type 3'b000 (level low): an enabled output is the inverse of its input, with the same latency as R4.
- R6: Trigger type 3'b110 (rising edge): each rising input transition gives exactly one single-cycle output pulse. A falling transition gives none.
- R7: Trigger type 3'b010 (falling edge): each falling input transition gives exactly one single-cycle output pulse. A rising transition gives none.
- R8: A disabled pin holds its output low, records no pending event and never raises `wake_req`, even while the domain is down.
- R9: While `domain_ready` is low, an edge event on an enabled edge pin gives no output pulse, sets the pin's pending bit and raises `wake_req`.
- R10: At the first clock edge with `domain_ready` high, every pending pin sends exactly one replay pulse, however many events it collected. `wake_req` then drops.
- R11: While `domain_ready` is low, an enabled level pin whose converted level is active raises `wake_req` and still drives its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_PINS | Raw peripheral interrupt lines (asynchronous) |
| domain_ready | input | 1 | High while the main domain is powered and able to take interrupts |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_out | output | NUM_PINS | Normalized active-high level or rising pulse per pin |
| wake_req | output | 1 | Request to power up the main domain |

## Verification
The bench goes after the address map at its edges. The last enable word is only partly populated, the word past it must read zero, and the trigger registers must drop bit 0 and the upper bits. A decoder off by one bank or one bit would read back the wrong word or stray ones. It checks that both edge types pulse once per transition and stay silent on the opposite transition. A design that forwards edges as levels would hold the output high over many cycles. The sleep scenario gives one pin two rising edges and another pin a falling edge while the domain is down. It expects no pulses during sleep, a wake request, and then exactly one replay pulse per pin on wake. A design that replays per event, forgets pending state, or leaks pulses during sleep would show a wrong pulse count. A disabled pin toggled during sleep must neither wake the domain nor replay later.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;
   // Byte offsets of the two register groups
   localparam int unsigned EN_BASE_B  = 32'h10;
   localparam int unsigned CFG_BASE_B = 32'h110;
   localparam int unsigned MAX_PINS   = 126;
   localparam int unsigned WORD_BITS  = 32;

   // Stored trigger configuration (bit 2 and bit 1 of the register)
   typedef struct packed {
      logic act_high;   // register bit 2
      logic is_edge;    // register bit 1
   } trig_cfg_t;

   localparam trig_cfg_t TRIG_RESET = '{act_high: 1'b1, is_edge: 1'b0};

   function automatic logic [31:0] cfg_to_word(trig_cfg_t c);
      return {29'b0, c.act_high, c.is_edge, 1'b0};
   endfunction
endpackage

// File: rtl/wake_irq_regs.sv
module wake_irq_regs
   import wake_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 126,
   parameter int unsigned ADDR_W   = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   output logic [NUM_PINS-1:0]      en_q,
   output trig_cfg_t [NUM_PINS-1:0] cfg_q
);
   localparam int unsigned WA      = ADDR_W - 2;
   localparam int unsigned EN_W    = EN_BASE_B / 4;
   localparam int unsigned CFG_W   = CFG_BASE_B / 4;

   logic [WA-1:0] word_a;
   logic [31:0]   rd_val;
   logic [1:0]    unused_lsb;

   assign word_a     = reg_addr[ADDR_W-1:2];
   assign unused_lsb = reg_addr[1:0];

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_reg
      localparam logic [WA-1:0] EN_ADR  = WA'(EN_W + i / WORD_BITS);
      localparam logic [WA-1:0] CFG_ADR = WA'(CFG_W + i);
      localparam int unsigned   BIT_POS = i % WORD_BITS;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[i]  <= 1'b0;
            cfg_q[i] <= TRIG_RESET;
         end else if (reg_wr) begin
            if (word_a == EN_ADR)
               en_q[i] <= reg_wdata[BIT_POS];
            if (word_a == CFG_ADR)
               cfg_q[i] <= '{act_high: reg_wdata[2], is_edge: reg_wdata[1]};
         end
      end
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (word_a == WA'(EN_W + i / WORD_BITS))
            rd_val[i % WORD_BITS] = en_q[i];
         if (word_a == WA'(CFG_W + i))
            rd_val = cfg_to_word(cfg_q[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rdata <= '0;
      else if (reg_rd)
         reg_rdata <= rd_val;
   end
endmodule

// File: rtl/wake_irq_lane.sv
module wake_irq_lane
   import wake_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      raw_in,
   input  logic      en,
   input  trig_cfg_t cfg,
   input  logic      ready,
   output logic      out_q,
   output logic      pend_q,
   output logic      lvl_wake
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic conv, conv_prev_q, rise, fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sync_q <= '0;
      else
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
   end

   // Polarity conversion: low-active types are inverted
   assign conv = cfg.act_high ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];
   assign rise = conv & ~conv_prev_q;
   assign fire = en & cfg.is_edge & ready & (rise | pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_prev_q <= 1'b0;
         pend_q      <= 1'b0;
         out_q       <= 1'b0;
      end else begin
         conv_prev_q <= conv;
         pend_q      <= en & cfg.is_edge & ~ready & (pend_q | rise);
         out_q       <= en & (cfg.is_edge ? fire : conv);
      end
   end

   assign lvl_wake = en & ~cfg.is_edge & conv & ~ready;
endmodule

// File: rtl/wake_irq_norm.sv
module wake_irq_norm
   import wake_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 126,
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_in,
   input  logic                domain_ready,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic [NUM_PINS-1:0] irq_out,
   output logic                wake_req
);
   localparam int unsigned MAP_END_B = CFG_BASE_B + 4 * NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("wake_irq_norm: NUM_PINS out of range");
   end
   if (MAP_END_B > (1 << ADDR_W)) begin : g_bad_addr
      $error("wake_irq_norm: ADDR_W too narrow for the register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wake_irq_norm: at least two synchronizer stages required");
   end

   logic [NUM_PINS-1:0]      en_q;
   trig_cfg_t [NUM_PINS-1:0] cfg_q;
   logic [NUM_PINS-1:0]      pend_vec;
   logic [NUM_PINS-1:0]      lvl_wake_vec;
   logic [NUM_PINS-1:0]      edge_vec;

   wake_irq_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .en_q     (en_q),
      .cfg_q    (cfg_q)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
      wake_irq_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_in  (irq_in[i]),
         .en      (en_q[i]),
         .cfg     (cfg_q[i]),
         .ready   (domain_ready),
         .out_q   (irq_out[i]),
         .pend_q  (pend_vec[i]),
         .lvl_wake(lvl_wake_vec[i])
      );
      assign edge_vec[i] = cfg_q[i].is_edge;
   end

   assign wake_req = (|pend_vec) | (|lvl_wake_vec);
endmodule

// File: rtl/wake_irq_norm_chk.sv
module wake_irq_norm_chk #(
   parameter int unsigned NUM_PINS = 126
) (
   input logic                clk,
   input logic                rst_n,
   input logic                domain_ready,
   input logic [NUM_PINS-1:0] irq_out,
   input logic                wake_req,
   input logic [NUM_PINS-1:0] en_vec,
   input logic [NUM_PINS-1:0] edge_vec,
   input logic [NUM_PINS-1:0] pend_vec
);
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0) && !wake_req); // R1

   AST_AWAKE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (domain_ready && $past(domain_ready)) |-> !wake_req); // R10

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
      AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !en_vec[i] |=> !irq_out[i]); // R8

      AST_DISABLED_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         !en_vec[i] |=> !pend_vec[i]); // R8

      AST_NO_PULSE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_vec[i] && !domain_ready) |=> !irq_out[i]); // R9
   end
endmodule

bind wake_irq_norm wake_irq_norm_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .domain_ready(domain_ready),
   .irq_out     (irq_out),
   .wake_req    (wake_req),
   .en_vec      (en_q),
   .edge_vec    (edge_vec),
   .pend_vec    (pend_vec)
);

// File: tb/tb_wake_irq_norm.sv
`timescale 1ns/1ps
module tb_wake_irq_norm;
   localparam int N  = 126;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          domain_ready = 1'b1;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  irq_out;
   logic          wake_req;

   int n_checks = 0;
   int n_fail   = 0;
   int watch_pin = 0;
   int pulse_cnt = 0;
   logic [31:0] bank_sh [0:3];

   always #2 clk = ~clk;

   wake_irq_norm #(.NUM_PINS(N), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .domain_ready(domain_ready),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out), .wake_req(wake_req)
   );

   always @(negedge clk) if (rst_n && irq_out[watch_pin]) pulse_cnt++;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = AW'(a);
      @(negedge clk);
      d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   task automatic set_en(input int p, input bit v);
      bank_sh[p/32][p%32] = v;
      wr(32'h10 + 4*(p/32), bank_sh[p/32]);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk(irq_out == '0, "R1 outputs", 32'(irq_out[31:0]), 0);
      chk(!wake_req, "R1 wake", 32'(wake_req), 0);
      rd(32'h10, d); chk(d == 0, "R1 enable word", d, 0);
      rd(32'h110, d); chk(d == 32'h4, "R1 trigger reset", d, 32'h4);
   endtask

   task automatic t_regs;
      logic [31:0] d;
      wr(32'h1C, 32'hFFFF_FFFF);
      rd(32'h1C, d); chk(d == 32'h3FFF_FFFF, "R2 partial last word", d, 32'h3FFF_FFFF);
      wr(32'h20, 32'hFFFF_FFFF);
      rd(32'h20, d); chk(d == 0, "R2 word past end", d, 0);
      wr(32'h1C, 32'h0);
      rd(32'h1C, d); chk(d == 0, "R2 clear readback", d, 0);
      wr(32'h124, 32'hFFFF_FFFF);
      rd(32'h124, d); chk(d == 32'h6, "R3 trigger masking", d, 32'h6);
      wr(32'h124, 32'h4);
   endtask

   task automatic t_level_high;   // pin 5
      wr(32'h110 + 4*5, 32'h4);
      set_en(5, 1'b1);
      @(negedge clk); irq_in[5] = 1'b1;
      settle(2); chk(irq_out[5] == 1'b0, "R4 latency early", 32'(irq_out[5]), 0);
      settle(1); chk(irq_out[5] == 1'b1, "R4 level follows", 32'(irq_out[5]), 1);
      irq_in[5] = 1'b0;
      settle(3); chk(irq_out[5] == 1'b0, "R4 level release", 32'(irq_out[5]), 0);
   endtask

   task automatic t_level_low;    // pin 40
      irq_in[40] = 1'b1;
      wr(32'h110 + 4*40, 32'h0);
      set_en(40, 1'b1);
      settle(3); chk(irq_out[40] == 1'b0, "R5 idle high inactive", 32'(irq_out[40]), 0);
      irq_in[40] = 1'b0;
      settle(3); chk(irq_out[40] == 1'b1, "R5 low asserts", 32'(irq_out[40]), 1);
      irq_in[40] = 1'b1;
      settle(3); chk(irq_out[40] == 1'b0, "R5 release", 32'(irq_out[40]), 0);
   endtask

   task automatic t_rise;         // pin 0
      wr(32'h110, 32'h6);
      set_en(0, 1'b1);
      settle(4);
      watch_pin = 0; pulse_cnt = 0;
      irq_in[0] = 1'b1; settle(6);
      chk(pulse_cnt == 1, "R6 one pulse per rise", 32'(pulse_cnt), 1);
      irq_in[0] = 1'b0; settle(6);
      chk(pulse_cnt == 1, "R6 no pulse on fall", 32'(pulse_cnt), 1);
      for (int k = 0; k < 2; k++) begin
         irq_in[0] = 1'b1; settle(5); irq_in[0] = 1'b0; settle(5);
      end
      chk(pulse_cnt == 3, "R6 repeated rises", 32'(pulse_cnt), 3);
   endtask

   task automatic t_fall;         // pin 125
      irq_in[125] = 1'b1;
      wr(32'h110 + 4*125, 32'h2);
      settle(4);
      set_en(125, 1'b1);
      settle(4);
      watch_pin = 125; pulse_cnt = 0;
      irq_in[125] = 1'b0; settle(6);
      chk(pulse_cnt == 1, "R7 one pulse per fall", 32'(pulse_cnt), 1);
      irq_in[125] = 1'b1; settle(6);
      chk(pulse_cnt == 1, "R7 no pulse on rise", 32'(pulse_cnt), 1);
   endtask

   task automatic t_disabled;     // pin 0 masked
      set_en(0, 1'b0);
      watch_pin = 0; pulse_cnt = 0;
      irq_in[0] = 1'b1; settle(5); irq_in[0] = 1'b0; settle(5);
      chk(pulse_cnt == 0, "R8 masked no output", 32'(pulse_cnt), 0);
      domain_ready = 1'b0;
      irq_in[0] = 1'b1; settle(5);
      chk(!wake_req, "R8 masked no wake", 32'(wake_req), 0);
      irq_in[0] = 1'b0; settle(3);
      domain_ready = 1'b1; settle(1);
      set_en(0, 1'b1);
      settle(4);
      chk(pulse_cnt == 0, "R8 masked no replay", 32'(pulse_cnt), 0);
   endtask

   task automatic t_sleep;        // pins 0 (rise) and 125 (fall)
      watch_pin = 0; pulse_cnt = 0;
      domain_ready = 1'b0;
      irq_in[0] = 1'b1; settle(3);
      chk(wake_req, "R9 wake on edge", 32'(wake_req), 1);
      irq_in[0] = 1'b0; settle(3);
      irq_in[0] = 1'b1; settle(3);
      irq_in[125] = 1'b0; settle(4);
      chk(pulse_cnt == 0, "R9 no pulse asleep", 32'(pulse_cnt), 0);
      chk(irq_out[125] == 1'b0, "R9 no pulse asleep pin125", 32'(irq_out[125]), 0);
      domain_ready = 1'b1;
      settle(1);
      chk(irq_out[0] && irq_out[125], "R10 replay pulses",
          {30'b0, irq_out[125], irq_out[0]}, 32'h3);
      chk(!wake_req, "R10 wake drops", 32'(wake_req), 0);
      settle(1);
      chk(!irq_out[0] && !irq_out[125], "R10 replay single cycle",
          {30'b0, irq_out[125], irq_out[0]}, 0);
      settle(4);
      chk(pulse_cnt == 1, "R10 one replay for two events", 32'(pulse_cnt), 1);
      irq_in[0] = 1'b0; irq_in[125] = 1'b1; settle(4);
   endtask

   task automatic t_level_wake;   // pin 5 level high asleep
      domain_ready = 1'b0;
      irq_in[5] = 1'b1; settle(3);
      chk(wake_req, "R11 level wakes", 32'(wake_req), 1);
      chk(irq_out[5], "R11 level still driven", 32'(irq_out[5]), 1);
      irq_in[5] = 1'b0; settle(3);
      chk(!wake_req, "R11 wake follows level", 32'(wake_req), 0);
      domain_ready = 1'b1; settle(2);
   endtask

   initial begin
      for (int b = 0; b < 4; b++) bank_sh[b] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_level_high();
      t_level_low();
      t_rise();
      t_fall();
      t_disabled();
      t_sleep();
      t_level_wake();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule